// File: doc/BRIEF.md
# Four-Lane Pre-Adder Multiply-Add with Systolic Chaining

This block is a signed multiply-add datapath with four identical lanes. Each lane can form a sum or difference of two operands ahead of its multiplier. The multiplier's second operand can be the same pre-adder result, a separate data input, or a constant taken from a per-lane table of eight coefficients. Each lane's product is then added to or subtracted from a running total that begins with a chain input. A block earlier in a cascade drives that chain input.

A configuration input picks the operand mode. The same mode applies to all four lanes and is held steady while data flows. A second configuration input picks between two summation structures. The flat structure adds all products in one adder tree. The systolic structure delays the inputs of lane i by i extra register stages and passes a partial sum from lane to lane. Both structures give the same numeric result and differ only in latency. The output can drive the chain input of the next block. A clock enable freezes every register, and an active-low asynchronous reset clears every register.

Top module: `preadd_sys_mac`

## Requirements
- R1: Mode code 0 (simple): each lane contributes a*b, and the result appears 3 enabled clock edges after the inputs are sampled when the flat structure is selected.
- R2: Mode code 1 (coefficient): each lane contributes (a±b)*k, where k is entry sel of that lane's table. The table bits for lane l and entry e are at [(l*8+e)*COEF_W +: COEF_W] of the coefficient parameter.
- R3: Mode code 2 (external): each lane contributes (a±b)*c.
- R4: Mode code 3 (square): each lane contributes (a±b)*(a±b), which is never negative before the product direction is applied.
- R5: Mode code 4 (constant): each lane contributes a*k with k taken from the table as in R2. The b input has no effect on the result.
- R6: Pre-adder direction bit l set forms a-b for lane l, and clear forms a+b.
- R7: Product direction bit l set subtracts lane l's product from the total, and clear adds it.
- R8: The chain input sampled with an input set is added to that set's total.
- R9: With the systolic structure selected, the result equals the flat result and appears 3+LANES-1 enabled edges after sampling.
- R10: While the enable is low, no register changes and the output holds.
- R11: Reset low clears the output to zero. After reset is released, the output stays zero until the first sampled set reaches it.
- R12: The result is exact at the operand extremes (all operands -128, square mode, all products added or all subtracted, a large chain value). The result is RES_W bits wide: 2*(max operand width+1) bits for a product, plus log2(LANES)+1 guard bits.
- Lane l operands sit at [l*W +: W] of each packed operand port. Mode codes 5 to 7 behave like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| en_i | input | 1 | Clock enable for all registers |
| mode_i | input | 3 | Operand mode code (quasi-static) |
| sys_i | input | 1 | 1 selects the systolic structure (quasi-static) |
| a_i | input | LANES*A_W | Signed first operands, packed by lane |
| b_i | input | LANES*B_W | Signed second operands, packed by lane |
| c_i | input | LANES*C_W | Signed external multiplicands, packed by lane |
| sel_i | input | LANES*SEL_W | Coefficient table index per lane |
| psub_i | input | LANES | Pre-adder direction per lane |
| msub_i | input | LANES | Product direction per lane |
| chain_i | input | RES_W | Signed chain input from a previous block |
| result_o | output | RES_W | Signed total, usable as the next block's chain input |

## Verification
Each of the five operand modes is driven with random operands, random coefficient indices, random pre-adder and product directions, random chain values and random enable gaps. A wrong operand choice, a wrong table index, a wrong sign or a lost chain input each move the result away from the model's value. The same mode sweep is then repeated with the systolic structure. This shows whether the per-lane delays and the partial-sum chain keep the sets aligned at the longer latency. Extreme operands test for width overflow. Resets during operation and enable-low cycles show that the datapath clears and holds.

// File: rtl/preadd_mac_pkg.sv
package preadd_mac_pkg;
  typedef enum logic [2:0] {
    PM_SIMPLE = 3'd0,
    PM_COEF   = 3'd1,
    PM_INPUT  = 3'd2,
    PM_SQUARE = 3'd3,
    PM_CONST  = 3'd4
  } pa_mode_e;
endpackage

// File: rtl/mac_tap_delay.sv
module mac_tap_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else if (en_i) begin
      sr_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/mac_lane.sv
module mac_lane import preadd_mac_pkg::*; #(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter int C_W    = 8,
  parameter int COEF_W = 8,
  parameter int SEL_W  = 3,
  parameter int OP_W   = 9,
  parameter int PROD_W = 18,
  parameter int DEPTH  = 0,
  parameter logic [(2**SEL_W)*COEF_W-1:0] COEFS = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sys_i,
  input  pa_mode_e          mode_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  input  logic [C_W-1:0]    c_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              psub_i,
  input  logic              msub_i,
  output logic [PROD_W-1:0] term_o
);
  localparam int BW = A_W + B_W + C_W + SEL_W + 2;

  logic [BW-1:0] raw, dly, pick;
  assign raw = {msub_i, psub_i, sel_i, c_i, b_i, a_i};

  // lane position sets the systolic skew
  if (DEPTH > 0) begin : g_skew
    mac_tap_delay #(.W(BW), .DEPTH(DEPTH)) i_skew (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .d_i(raw), .q_o(dly)
    );
  end else begin : g_noskew
    assign dly = raw;
  end

  assign pick = sys_i ? dly : raw;

  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic [C_W-1:0]   c_q;
  logic [SEL_W-1:0] sel_q;
  logic             psub_q, msub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {msub_q, psub_q, sel_q, c_q, b_q, a_q} <= '0;
    end else if (en_i) begin
      {msub_q, psub_q, sel_q, c_q, b_q, a_q} <= pick;
    end
  end

  logic signed [OP_W-1:0] a_x, b_x, c_x, k_x, pre, op_x, op_y;
  logic [COEF_W-1:0] k_raw;

  assign k_raw = COEFS[sel_q*COEF_W +: COEF_W];
  assign a_x   = OP_W'($signed(a_q));
  assign b_x   = OP_W'($signed(b_q));
  assign c_x   = OP_W'($signed(c_q));
  assign k_x   = OP_W'($signed(k_raw));
  assign pre   = psub_q ? (a_x - b_x) : (a_x + b_x);

  always_comb begin
    unique case (mode_i)
      PM_COEF:   begin op_x = pre; op_y = k_x; end
      PM_INPUT:  begin op_x = pre; op_y = c_x; end
      PM_SQUARE: begin op_x = pre; op_y = pre; end
      PM_CONST:  begin op_x = a_x; op_y = k_x; end
      default:   begin op_x = a_x; op_y = b_x; end
    endcase
  end

  logic signed [PROD_W-1:0] px, py, prod, term_q;
  assign px   = PROD_W'(op_x);
  assign py   = PROD_W'(op_y);
  assign prod = px * py;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   term_q <= '0;
    else if (en_i) term_q <= msub_q ? -prod : prod;
  end

  assign term_o = term_q;

  p_square_nonneg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == PM_SQUARE && !msub_q) |=> !term_q[PROD_W-1]);

  p_simple_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == PM_SIMPLE && a_q == '0) |=> term_q == '0);
endmodule

// File: rtl/mac_sum.sv
module mac_sum #(
  parameter int LANES  = 4,
  parameter int PROD_W = 18,
  parameter int RES_W  = 21
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    sys_i,
  input  logic [LANES*PROD_W-1:0] terms_i,
  input  logic [RES_W-1:0]        chain_i,
  output logic [RES_W-1:0]        sum_o
);
  logic signed [RES_W-1:0] t_x [LANES];
  logic signed [RES_W-1:0] flat_n, flat_q;
  logic signed [RES_W-1:0] acc_q [LANES];
  logic                    all_pos;

  always_comb begin
    flat_n  = $signed(chain_i);
    all_pos = !chain_i[RES_W-1];
    for (int l = 0; l < LANES; l++) begin
      t_x[l]  = RES_W'($signed(terms_i[l*PROD_W +: PROD_W]));
      flat_n  = flat_n + t_x[l];
      all_pos = all_pos & !terms_i[l*PROD_W + PROD_W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flat_q <= '0;
      for (int l = 0; l < LANES; l++) acc_q[l] <= '0;
    end else if (en_i) begin
      flat_q   <= flat_n;
      acc_q[0] <= $signed(chain_i) + t_x[0];
      for (int l = 1; l < LANES; l++) acc_q[l] <= acc_q[l-1] + t_x[l];
    end
  end

  assign sum_o = sys_i ? acc_q[LANES-1] : flat_q;

  p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && all_pos) |=> !flat_q[RES_W-1]);

  p_chain_head_sign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !chain_i[RES_W-1] && !terms_i[PROD_W-1]) |=> !acc_q[0][RES_W-1]);
endmodule

// File: rtl/preadd_sys_mac.sv
module preadd_sys_mac import preadd_mac_pkg::*; #(
  parameter int LANES  = 4,
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter int C_W    = 8,
  parameter int COEF_W = 8,
  parameter int SEL_W  = 3,
  parameter logic [LANES*(2**SEL_W)*COEF_W-1:0] COEFS =
    256'h0103_F7E2_1A44_9C05_7F80_3311_C2D4_0E60_FF02_1407_E9B3_5528_6A01_8C3E_2247_D00F,
  localparam int NCOEF  = 2**SEL_W,
  localparam int MAX_AB = (A_W > B_W) ? A_W : B_W,
  localparam int MAX_CK = (C_W > COEF_W) ? C_W : COEF_W,
  localparam int OP_W   = ((MAX_AB > MAX_CK) ? MAX_AB : MAX_CK) + 1,
  localparam int PROD_W = 2 * OP_W,
  localparam int RES_W  = PROD_W + $clog2(LANES) + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [2:0]             mode_i,
  input  logic                   sys_i,
  input  logic [LANES*A_W-1:0]   a_i,
  input  logic [LANES*B_W-1:0]   b_i,
  input  logic [LANES*C_W-1:0]   c_i,
  input  logic [LANES*SEL_W-1:0] sel_i,
  input  logic [LANES-1:0]       psub_i,
  input  logic [LANES-1:0]       msub_i,
  input  logic [RES_W-1:0]       chain_i,
  output logic [RES_W-1:0]       result_o
);
  pa_mode_e mode;
  assign mode = pa_mode_e'(mode_i);

  logic [LANES*PROD_W-1:0] terms;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    mac_lane #(
      .A_W(A_W), .B_W(B_W), .C_W(C_W), .COEF_W(COEF_W), .SEL_W(SEL_W),
      .OP_W(OP_W), .PROD_W(PROD_W), .DEPTH(l),
      .COEFS(COEFS[l*NCOEF*COEF_W +: NCOEF*COEF_W])
    ) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .sys_i  (sys_i),
      .mode_i (mode),
      .a_i    (a_i[l*A_W +: A_W]),
      .b_i    (b_i[l*B_W +: B_W]),
      .c_i    (c_i[l*C_W +: C_W]),
      .sel_i  (sel_i[l*SEL_W +: SEL_W]),
      .psub_i (psub_i[l]),
      .msub_i (msub_i[l]),
      .term_o (terms[l*PROD_W +: PROD_W])
    );
  end

  // chain input follows lane 0 through input and product stages
  logic [RES_W-1:0] chain_d1, chain_d2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_d1 <= '0;
      chain_d2 <= '0;
    end else if (en_i) begin
      chain_d1 <= chain_i;
      chain_d2 <= chain_d1;
    end
  end

  mac_sum #(.LANES(LANES), .PROD_W(PROD_W), .RES_W(RES_W)) i_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .sys_i   (sys_i),
    .terms_i (terms),
    .chain_i (chain_d2),
    .sum_o   (result_o)
  );

  p_hold_on_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i ##1 $stable(sys_i)) |-> $stable(result_o));
endmodule

// File: tb/test_preadd_sys_mac.sv
module test_preadd_sys_mac;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int W     = 8;
  localparam int SEL_W = 3;
  localparam int NCOEF = 8;
  localparam int RES_W = 21;

  function automatic int coef_of(int l, int k);
    return ((l * 8 + k) * 37) % 251 - 125;
  endfunction

  function automatic logic [LANES*NCOEF*W-1:0] build_coefs();
    logic [LANES*NCOEF*W-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < NCOEF; k++)
        r[(l*NCOEF+k)*W +: W] = 8'(coef_of(l, k));
    return r;
  endfunction

  localparam logic [LANES*NCOEF*W-1:0] TB_COEFS = build_coefs();

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic sys_i = 1'b0;
  logic [LANES*W-1:0] a_i = '0, b_i = '0, c_i = '0;
  logic [LANES*SEL_W-1:0] sel_i = '0;
  logic [LANES-1:0] psub_i = '0, msub_i = '0;
  logic [RES_W-1:0] chain_i = '0;
  logic [RES_W-1:0] result_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  preadd_sys_mac #(.COEFS(TB_COEFS)) i_preadd_sys_mac (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i), .sys_i(sys_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .sel_i(sel_i), .psub_i(psub_i),
    .msub_i(msub_i), .chain_i(chain_i), .result_o(result_o)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int q[$];
  int exp_v = 0;
  bit exp_ok = 0;
  bit en_prev = 0;
  int val_prev = 0;
  int cur_mode = 0;
  bit cur_sys = 0;
  int lat = 3;

  task automatic check(input string tag, input int expv);
    int got;
    got = int'($signed(result_o));
    n_checks++;
    if (got != expv) begin
      n_errors++;
      $display("FAIL %s: result got %0d expected %0d at %0t", tag, got, expv, $time);
    end
  endtask

  function automatic int lane_val(int mode, int l, int a, int b, int c, int sel, bit ps, bit ms);
    int pre, v;
    pre = ps ? a - b : a + b;
    case (mode)
      1: v = pre * coef_of(l, sel);
      2: v = pre * c;
      3: v = pre * pre;
      4: v = a * coef_of(l, sel);
      default: v = a * b;
    endcase
    return ms ? -v : v;
  endfunction

  task automatic step(input int mode, input bit sys, input int en_pct, input bit extreme,
                      input bit ext_neg, input string tag);
    int sum, a, b, c, s, ch;
    bit ps, ms, en;
    @(negedge clk);
    if (en_prev) begin
      q.push_back(val_prev);
      if (q.size() == lat) begin
        exp_v = q.pop_front();
        exp_ok = 1;
      end
    end
    if (exp_ok) check(en_prev ? tag : {tag, " R10"}, exp_v);
    if (mode != cur_mode || sys != cur_sys) begin
      q.delete();
      exp_ok = 0;
      cur_mode = mode;
      cur_sys = sys;
      lat = sys ? 3 + LANES - 1 : 3;
    end
    mode_i = 3'(mode);
    sys_i = sys;
    en = ($urandom % 100) < en_pct;
    en_i = en;
    ch = extreme ? (ext_neg ? -700000 : 700000) : int'($urandom % 400001) - 200000;
    chain_i = RES_W'(ch);
    sum = ch;
    for (int l = 0; l < LANES; l++) begin
      a  = extreme ? -128 : int'($urandom % 256) - 128;
      b  = extreme ? -128 : int'($urandom % 256) - 128;
      c  = int'($urandom % 256) - 128;
      s  = int'($urandom % NCOEF);
      ps = extreme ? 1'b0 : 1'($urandom);
      ms = extreme ? ext_neg : 1'($urandom);
      a_i[l*W +: W] = 8'(a);
      b_i[l*W +: W] = 8'(b);
      c_i[l*W +: W] = 8'(c);
      sel_i[l*SEL_W +: SEL_W] = 3'(s);
      psub_i[l] = ps;
      msub_i[l] = ms;
      sum += lane_val(mode, l, a, b, c, s, ps, ms);
    end
    val_prev = sum;
    en_prev = en;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_ni = 1'b0;
    en_i = 1'b0;
    @(negedge clk);
    check(tag, 0);
    @(negedge clk);
    check(tag, 0);
    rst_ni = 1'b1;
    q.delete();
    exp_v = 0;
    exp_ok = 1;
    en_prev = 0;
  endtask

  initial begin
    string mtag[5];
    mtag[0] = "R1"; mtag[1] = "R2"; mtag[2] = "R3"; mtag[3] = "R4"; mtag[4] = "R5";
    // R11: reset state, then zero until first set arrives
    do_reset("R11 reset");
    for (int i = 0; i < 8; i++) step(0, 0, 100, 0, 0, "R11 R1 after reset");
    // flat structure, every mode; directions and chain random (R6 R7 R8)
    for (int m = 0; m < 5; m++)
      for (int i = 0; i < 60; i++) step(m, 0, 80, 0, 0, {mtag[m], " R6 R7 R8"});
    // systolic structure, every mode
    for (int m = 0; m < 5; m++)
      for (int i = 0; i < 50; i++) step(m, 1, 80, 0, 0, {"R9 ", mtag[m]});
    // R12 extremes, both directions, both structures
    for (int i = 0; i < 12; i++) step(3, 0, 100, 1, i[0], "R12 flat");
    for (int i = 0; i < 16; i++) step(3, 1, 100, 1, i[0], "R12 systolic");
    // long enable-low stretch (R10)
    for (int i = 0; i < 20; i++) step(2, 0, 10, 0, 0, "R10 R3");
    // reset in mid-stream (R11)
    do_reset("R11 mid-run clear");
    for (int i = 0; i < 12; i++) step(1, 1, 100, 0, 0, "R11 R9 after clear");
    for (int i = 0; i < 10; i++) step(4, 0, 100, 0, 0, "R5 final");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule